// File: doc/BRIEF.md
# Display Transmitter Control Target with Display-Channel Handoff

This block is an I2C target that sits in front of a display transmitter's control registers. It watches a synchronised SCL/SDA pair and decodes START, STOP, its own 7-bit address, data bytes and the acknowledge slot. It keeps an 8-bit register index. In a write transaction the first data byte loads that index. After that, every byte read or written moves the index forward by one.

Most of the register space is inert. An identity location and an interrupt-status location return constant values, and every other location reads as zero. The system control location is the exception. A host sets a bus-request bit, and sets a grant bit alongside it, to hand the shared bus over to a downstream display-data channel. The block holds a mode output high while that handoff is in force, and a board uses that output to route the bus to the monitor-description memory. The mode is left only by a control write with the request bit clear, or by reset.

Top module: `i2c_regtarget_ddc`

## Requirements
- R1: The target acknowledges only its own 7-bit address (parameter `TARGET_ADDR`, address byte = address in bits 7..1, direction in bit 0, 0 = write). A foreign address is not acknowledged, and nothing on the bus affects the block until the next START.
- R2: In a write transaction, the first byte after the address byte loads the register index. That byte never acts as a register write.
- R3: After each data byte read or written, the index advances by one, modulo 256. Consecutive bytes in one transaction therefore reach consecutive locations, and index 0xFF is followed by 0x00.
- R4: Location 0x1B always reads 0xB0, and writes to it have no effect.
- R5: Location 0x3D always reads 0x04 (sink present, nothing pending). Location 0x3C accepts writes, which have no effect, and reads 0x00.
- R6: A write to location 0x1A with bit 2 (request) set sets the request flag. If bit 1 (grant) is also set in the same byte, the `ddc_mode_o` output goes high. Bit 2 set with bit 1 clear leaves `ddc_mode_o` unchanged.
- R7: A write to location 0x1A with bit 2 clear clears both the request flag and `ddc_mode_o`, whatever the other bits hold.
- R8: Location 0x1A reads 0x06 while the request flag is set and 0x00 otherwise.
- R9: Any location other than 0x1A, 0x1B and 0x3D reads 0x00, and writes to it are acknowledged and have no effect.
- R10: A STOP or START never changes `ddc_mode_o`. This includes the STOP that ends the transaction which raised it.
- R11: Reset clears the index to 0x00, clears the pending index-load flag, the request flag and `ddc_mode_o`, and releases SDA.
- R12: In a read, the target shifts out a byte MSB first and continues after a master ACK. A master NACK ends the read, and SDA stays released until the next START. During well-formed traffic, `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| ddc_mode_o | output | 1 | High while the bus is handed to the display-data channel |

## Verification
The bench builds the block with `TARGET_ADDR` = 0x3B instead of the default, and with `SYNC_STAGES` = 3. The changed address shows that matching follows the parameter and does not depend on a fixed value. The deeper synchroniser stretches the delay between a bus edge and the target's response. With that extra latency, the bench shows that acknowledge and read-data timing still fall inside the SCL low phase, and that the index wrap and long read bursts come out right. An index wrap is confirmed by a single write burst that starts at 0xFF and reaches the control location only after wrapping.

// File: rtl/i2c_ddc_pkg.sv
// Package: shared types and register constants for the I2C control target.
// Assumes 8-bit registers and an 8-bit register index.
package i2c_ddc_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Register locations that carry behaviour.
    localparam byte_t LOC_SYSCTL   = 8'h1A;
    localparam byte_t LOC_IDENT    = 8'h1B;
    localparam byte_t LOC_IRQ_MASK = 8'h3C;
    localparam byte_t LOC_IRQ_STAT = 8'h3D;

    // Fixed read values.
    localparam byte_t IDENT_VALUE    = 8'hB0;
    localparam byte_t IRQ_STAT_VALUE = 8'h04;

    // Control bit positions.
    localparam int CTL_REQ_BIT = 2;
    localparam int CTL_GNT_BIT = 1;
    localparam byte_t CTL_ECHO = byte_t'((1 << CTL_REQ_BIT) | (1 << CTL_GNT_BIT));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_TX,
        ST_MACK_RISE,
        ST_MACK_FALL
    } eng_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clk domain through STAGES flops each. Flags
// SCL edges, and START/STOP as SDA edges while SCL is high.
// Assumes clk is many times faster than SCL and STAGES >= 2.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_q;
    logic          scl_d;
    logic          sda_d;

    // Synchroniser chains, one flop per stage; bus idles high.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[0] <= 1'b1;
                        sda_pipe[0] <= 1'b1;
                    end else begin
                        scl_pipe[0] <= scl_i;
                        sda_pipe[0] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[g] <= 1'b1;
                        sda_pipe[g] <= 1'b1;
                    end else begin
                        scl_pipe[g] <= scl_pipe[g-1];
                        sda_pipe[g] <= sda_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_q = scl_pipe[LAST];
    assign sda_s = sda_pipe[LAST];

    // Previous synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q;
            sda_d <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_rise  = scl_q & ~scl_d;
        scl_fall  = ~scl_q & scl_d;
        start_det = scl_q & scl_d & sda_d & ~sda_s;
        stop_det  = scl_q & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_byte_engine.sv
// Module: i2c_byte_engine
// Bit-level target state machine: receives the address and data bytes,
// drives ACK, shifts read data out MSB first, and reacts to master ACK/NACK.
// Pulses hit_wr on a matching write address, wr_stb per received data
// byte, and rd_stb when a read byte is taken from rd_byte.
// Assumes synchronised edge strobes from i2c_line_sync.
module i2c_byte_engine
    import i2c_ddc_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h39
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sda_s,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  start_det,
    input  logic  stop_det,
    input  byte_t rd_byte,
    output logic  sda_oe,
    output logic  hit_wr,
    output logic  wr_stb,
    output byte_t wr_byte,
    output logic  rd_stb
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    eng_state_t       state;
    logic [CNT_W-1:0] cnt;
    byte_t            shreg;
    logic             is_addr;
    logic             rd_mode;
    byte_t            rx_full;

    // The byte as it stands once the current bit is shifted in.
    assign rx_full = {shreg[BYTE_W-2:0], sda_s};

    // Protocol sequencing; strobes are single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            is_addr <= 1'b0;
            rd_mode <= 1'b0;
            sda_oe  <= 1'b0;
            hit_wr  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_byte <= '0;
            rd_stb  <= 1'b0;
        end else begin
            hit_wr <= 1'b0;
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (start_det) begin
                state   <= ST_RX;
                is_addr <= 1'b1;
                cnt     <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg <= rx_full;
                            cnt   <= cnt + 1'b1;
                            if (cnt == CNT_LAST) begin
                                if (is_addr) begin
                                    if (rx_full[7:1] == TARGET_ADDR) begin
                                        rd_mode <= rx_full[0];
                                        hit_wr  <= ~rx_full[0];
                                        state   <= ST_ACK_WAIT;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else begin
                                    wr_stb  <= 1'b1;
                                    wr_byte <= rx_full;
                                    state   <= ST_ACK_WAIT;
                                end
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_DRIVE;
                        end
                    end
                    ST_ACK_DRIVE: begin
                        if (scl_fall) begin
                            is_addr <= 1'b0;
                            cnt     <= '0;
                            if (rd_mode) begin
                                shreg  <= rd_byte;
                                rd_stb <= 1'b1;
                                sda_oe <= ~rd_byte[BYTE_W-1];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK_RISE;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK_RISE: begin
                        if (scl_rise) begin
                            state <= sda_s ? ST_IDLE : ST_MACK_FALL;
                        end
                    end
                    ST_MACK_FALL: begin
                        if (scl_fall) begin
                            cnt    <= '0;
                            shreg  <= rd_byte;
                            rd_stb <= 1'b1;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                            state  <= ST_TX;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ddc_reg_block.sv
// Module: ddc_reg_block
// Register index, fixed read values and the request/grant handoff state.
// A pending index load (set by a write address match) makes the next
// received byte the index. Other bytes are register writes and advance
// the index, as does every read strobe.
// Assumes hit_wr, wr_stb and rd_stb are never high in the same cycle.
module ddc_reg_block
    import i2c_ddc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hit_wr,
    input  logic  wr_stb,
    input  byte_t wr_byte,
    input  logic  rd_stb,
    output byte_t rd_byte,
    output logic  ddc_mode_o
);
    byte_t ptr_q;
    logic  ptr_pending;
    logic  req_flag;

    // Index, pending-load flag and handoff flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            ptr_pending <= 1'b0;
            req_flag    <= 1'b0;
            ddc_mode_o  <= 1'b0;
        end else begin
            if (hit_wr) begin
                ptr_pending <= 1'b1;
            end
            if (wr_stb) begin
                if (ptr_pending) begin
                    ptr_q       <= wr_byte;
                    ptr_pending <= 1'b0;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                    if (ptr_q == LOC_SYSCTL) begin
                        if (wr_byte[CTL_REQ_BIT]) begin
                            req_flag <= 1'b1;
                            if (wr_byte[CTL_GNT_BIT]) begin
                                ddc_mode_o <= 1'b1;
                            end
                        end else begin
                            req_flag   <= 1'b0;
                            ddc_mode_o <= 1'b0;
                        end
                    end
                end
            end
            if (rd_stb) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Read value for the current index.
    always_comb begin
        case (ptr_q)
            LOC_SYSCTL:   rd_byte = req_flag ? CTL_ECHO : '0;
            LOC_IDENT:    rd_byte = IDENT_VALUE;
            LOC_IRQ_STAT: rd_byte = IRQ_STAT_VALUE;
            default:      rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/i2c_regtarget_ddc.sv
// Module: i2c_regtarget_ddc (top)
// I2C register target for a display transmitter, with a request/grant
// handoff to a display-data channel. SDA is open-drain: sda_oe_o high
// pulls the line low. Assumes clk is at least 16x the SCL rate.
module i2c_regtarget_ddc
    import i2c_ddc_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h39,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic ddc_mode_o
);
    logic  sda_s;
    logic  scl_rise;
    logic  scl_fall;
    logic  start_det;
    logic  stop_det;
    logic  hit_wr;
    logic  wr_stb;
    byte_t wr_byte;
    logic  rd_stb;
    byte_t rd_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_engine #(.TARGET_ADDR(TARGET_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe_o),
        .hit_wr    (hit_wr),
        .wr_stb    (wr_stb),
        .wr_byte   (wr_byte),
        .rd_stb    (rd_stb)
    );

    ddc_reg_block u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_wr     (hit_wr),
        .wr_stb     (wr_stb),
        .wr_byte    (wr_byte),
        .rd_stb     (rd_stb),
        .rd_byte    (rd_byte),
        .ddc_mode_o (ddc_mode_o)
    );
endmodule

// File: rtl/i2c_regtarget_ddc_chk.sv
// Module: i2c_regtarget_ddc_chk
// Temporal checks on the control target, bound to the top module.
module i2c_regtarget_ddc_chk
    import i2c_ddc_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  scl_q,
    input logic  sda_oe,
    input logic  ddc_mode,
    input logic  req_flag,
    input logic  wr_stb,
    input byte_t wr_byte,
    input logic  rd_stb,
    input byte_t ptr,
    input logic  ptr_pending
);
    assert_grant_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ddc_mode |-> req_flag);

    assert_mode_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ddc_mode) |-> $past(wr_stb && !ptr_pending && ptr == LOC_SYSCTL
                                  && wr_byte[CTL_REQ_BIT] && wr_byte[CTL_GNT_BIT]));

    // R7 and R10: only a control write with request clear ends the mode.
    assert_mode_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ddc_mode) |-> $past(wr_stb && !ptr_pending && ptr == LOC_SYSCTL
                                  && !wr_byte[CTL_REQ_BIT]));

    assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || (wr_stb && !ptr_pending)) |=> (ptr == $past(ptr) + 8'd1));

    assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ptr_pending) |=> (ptr == $past(wr_byte) && $stable(ddc_mode)));

    assert_oe_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_q);
endmodule

bind i2c_regtarget_ddc i2c_regtarget_ddc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_q       (u_sync.scl_q),
    .sda_oe      (sda_oe_o),
    .ddc_mode    (ddc_mode_o),
    .req_flag    (u_regs.req_flag),
    .wr_stb      (wr_stb),
    .wr_byte     (wr_byte),
    .rd_stb      (rd_stb),
    .ptr         (u_regs.ptr_q),
    .ptr_pending (u_regs.ptr_pending)
);

// File: tb/i2c_regtarget_ddc_bench.sv
// Bench: a vector table walked by one loop, then directed corner cases.
module i2c_regtarget_ddc_bench;
    localparam logic [6:0] DUT_ADDR = 7'h3B;
    localparam int Q = 8;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_DDC = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  loc;
        logic [7:0]  wd;
        logic [7:0]  exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [0:NV-1] = '{
        '{OP_RD,  8'h1B, 8'h00, 8'hB0, "R4 "},
        '{OP_RD,  8'h3D, 8'h00, 8'h04, "R5 "},
        '{OP_RD,  8'h1A, 8'h00, 8'h00, "R8 "},
        '{OP_WR,  8'h3C, 8'hFF, 8'h00, "R5 "},
        '{OP_RD,  8'h3C, 8'h00, 8'h00, "R5 "},
        '{OP_WR,  8'h1B, 8'h12, 8'h00, "R4 "},
        '{OP_RD,  8'h1B, 8'h00, 8'hB0, "R4 "},
        '{OP_WR,  8'h1A, 8'h04, 8'h00, "R6 "},
        '{OP_DDC, 8'h00, 8'h00, 8'h00, "R6 "},
        '{OP_RD,  8'h1A, 8'h00, 8'h06, "R8 "},
        '{OP_WR,  8'h1A, 8'h06, 8'h00, "R6 "},
        '{OP_DDC, 8'h00, 8'h00, 8'h01, "R6 "},
        '{OP_WR,  8'h1A, 8'h15, 8'h00, "R6 "},
        '{OP_DDC, 8'h00, 8'h00, 8'h01, "R10"},
        '{OP_RD,  8'h1A, 8'h00, 8'h06, "R8 "},
        '{OP_WR,  8'h1A, 8'h03, 8'h00, "R7 "},
        '{OP_DDC, 8'h00, 8'h00, 8'h00, "R7 "},
        '{OP_RD,  8'h1A, 8'h00, 8'h00, "R7 "},
        '{OP_WR,  8'h55, 8'hAA, 8'h00, "R9 "},
        '{OP_RD,  8'h55, 8'h00, 8'h00, "R9 "},
        '{OP_RD,  8'hC0, 8'h00, 8'h00, "R9 "}
    };

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic ddc_mode;
    logic sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    int hi_changes = 0;
    logic oe_prev = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_regtarget_ddc #(.TARGET_ADDR(DUT_ADDR), .SYNC_STAGES(3)) u_i2c_regtarget_ddc (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .ddc_mode_o (ddc_mode)
    );

    // R12 monitor: SDA enable must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe !== oe_prev)) hi_changes++;
        oe_prev = sda_oe;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(nack);
    endtask

    task automatic recv_byte(input logic master_nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(master_nack);
    endtask

    // Single write: address, index, one data byte. Returns OR of NACKs.
    task automatic wr_reg(input logic [7:0] loc, input logic [7:0] d, output logic any_nack);
        logic n0, n1, n2;
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, n0);
        send_byte(loc, n1);
        send_byte(d, n2);
        bus_stop();
        any_nack = n0 | n1 | n2;
    endtask

    // Index write, repeated START, one read byte closed with NACK.
    task automatic rd_reg(input logic [7:0] loc, output logic [7:0] d);
        logic n;
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, n);
        send_byte(loc, n);
        bus_start();
        send_byte({DUT_ADDR, 1'b1}, n);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic       nk;
        logic [7:0] rv;
        tick(5);
        // R11: reset state at the ports.
        check("R11 reset ddc_mode", {7'd0, ddc_mode}, 8'h00);
        check("R11 reset sda_oe", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        tick(4 * Q);

        // Vector table.
        for (int k = 0; k < NV; k++) begin
            case (VECS[k].op)
                OP_WR: begin
                    wr_reg(VECS[k].loc, VECS[k].wd, nk);
                    check($sformatf("%s write ack loc %02h", VECS[k].tag, VECS[k].loc),
                          {7'd0, nk}, 8'h00);
                end
                OP_RD: begin
                    rd_reg(VECS[k].loc, rv);
                    check($sformatf("%s read loc %02h", VECS[k].tag, VECS[k].loc),
                          rv, VECS[k].exp);
                end
                default: begin
                    tick(Q);
                    check($sformatf("%s ddc_mode", VECS[k].tag), {7'd0, ddc_mode}, VECS[k].exp);
                end
            endcase
        end

        // R1: a foreign address is not acknowledged and has no effect.
        bus_start();
        send_byte({7'h22, 1'b0}, nk);
        check("R1 foreign address NACK", {7'd0, nk}, 8'h01);
        send_byte(8'h1A, nk);
        send_byte(8'h06, nk);
        bus_stop();
        check("R1 foreign write ignored", {7'd0, ddc_mode}, 8'h00);

        // R3: a burst from 0x19 reaches 0x1A on its second data byte.
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, nk);
        send_byte(8'h19, nk);
        send_byte(8'h55, nk);
        send_byte(8'h06, nk);
        bus_stop();
        check("R3 burst write reaches 0x1A", {7'd0, ddc_mode}, 8'h01);

        // R2: the index byte is not a register write (index left at 0x1A).
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, nk);
        send_byte(8'h19, nk);
        send_byte(8'h00, nk);
        bus_stop();
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, nk);
        send_byte(8'h00, nk);
        bus_stop();
        check("R2 index byte not written", {7'd0, ddc_mode}, 8'h01);

        // R10: bare START/STOP leaves the mode alone.
        bus_start();
        bus_stop();
        tick(Q);
        check("R10 start/stop keeps mode", {7'd0, ddc_mode}, 8'h01);

        // R3 and R12: read burst 0x1A..0x1C with ACK, ACK, NACK.
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, nk);
        send_byte(8'h1A, nk);
        bus_start();
        send_byte({DUT_ADDR, 1'b1}, nk);
        recv_byte(1'b0, rv);
        check("R3 burst read 0x1A", rv, 8'h06);
        recv_byte(1'b0, rv);
        check("R3 burst read 0x1B", rv, 8'hB0);
        recv_byte(1'b1, rv);
        check("R3 burst read 0x1C", rv, 8'h00);
        // R12: after NACK, SDA stays released while SCL keeps toggling.
        begin
            logic [7:0] idle_bits;
            for (int i = 7; i >= 0; i--) recv_bit(idle_bits[i]);
            check("R12 released after NACK", idle_bits, 8'hFF);
        end
        bus_stop();

        // R3: index wraps from 0xFF to 0x00 and climbs to 0x1A.
        bus_start();
        send_byte({DUT_ADDR, 1'b0}, nk);
        send_byte(8'hFF, nk);
        send_byte(8'h00, nk);
        for (int i = 0; i < 26; i++) send_byte(8'h00, nk);
        send_byte(8'h03, nk);
        bus_stop();
        check("R3 wrap then write 0x1A clears mode", {7'd0, ddc_mode}, 8'h00);

        // R11: reset mid-run clears mode, request and index.
        wr_reg(8'h1A, 8'h06, nk);
        check("R11 mode set before reset", {7'd0, ddc_mode}, 8'h01);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2 * Q);
        check("R11 mode cleared by reset", {7'd0, ddc_mode}, 8'h00);
        bus_start();
        send_byte({DUT_ADDR, 1'b1}, nk);
        for (int i = 0; i < 27; i++) begin
            recv_byte(1'b0, rv);
            if (i == 26) check("R11 request cleared (0x1A via index 0)", rv, 8'h00);
        end
        recv_byte(1'b1, rv);
        check("R11 index reset to 0 (byte 27 is 0x1B)", rv, 8'hB0);
        bus_stop();

        // R12: enable never changed while SCL high over the run.
        check("R12 sda_oe changes while SCL high", hi_changes[7:0], 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule